// File: doc/BRIEF.md
# Segment Selector Load Validator

This block checks a 16-bit segment selector before it is allowed into a segment register. A load request names the target register and carries the selector together with the current global and local descriptor table bases and limits. The block splits the selector into its fields and picks a table with the table-indicator bit. It then confirms that the whole 8-byte descriptor entry lies inside that table's limit. Only after that does it fetch the descriptor over a simple request/acknowledge memory port.

Once the descriptor has arrived, the block applies the type rules for the target register and then the presence rule. It ends with exactly one of two results. The first is a one-cycle load-done strobe that carries the selector and the descriptor fields to cache. The second is a one-cycle fault strobe that carries an exception vector and an error code. Null selectors have their own handling: a data register accepts a null selector and is marked null, while the code and stack registers refuse it. The validation steps through idle, decode, fetch, check and then either done or fault.

Top module: `seg_sel_validator`

## Requirements
- R1: After reset the block is idle. `busy`, `memReq`, `loadDone` and `faultValid` are all low.
- R2: Selector bit 2 selects the table: 0 selects the global table and 1 selects the local table. The descriptor is read from `memAddr` = table base + index × 8, where the index is selector bits 15:3.
- R3: If index × 8 + 7 exceeds the selected table's limit, the result is a fault on vector 13. The error code is the selector with bits 1:0 cleared, and no memory request is made.
- R4: A selector with bit 2 set while `ldtValid` is low faults on vector 13. The error code is the selector with bits 1:0 cleared, and no memory request is made.
- R5: A null selector (index 0 and bit 2 clear, any bits 1:0) aimed at CS (`targetReg`=1) or SS (`targetReg`=2) faults on vector 13 with error code 0 and makes no memory request.
- R6: A null selector aimed at any other target (0 and 3 to 7) completes with `loadDone` and `loadNull` high. The cached base, limit and attributes are zero, and no memory request is made.
- R7: The descriptor type rules are applied before presence. Bit 44 (the code/data flag) must be 1. CS needs a code type (bit 43 set). SS needs a writable data type (bit 43 clear, bit 41 set). The other targets accept data types, and code types only when readable (bit 41 set). A violation faults on vector 13 with the selector error code.
- R8: A descriptor that passes R7 but has bit 47 (present) clear faults on vector 12 when the target is SS and on vector 11 otherwise. The error code is the selector with bits 1:0 cleared.
- R9: A successful load pulses `loadDone` for one cycle with `loadNull` low and `loadSel` equal to the selector. The cached fields are taken from the descriptor as follows:
  - `cacheBase` = {bits 63:56, bits 39:16}
  - `cacheLimit` = {bits 51:48, bits 15:0}
  - `cacheAttr` = {bits 55:52, bits 47:40}
- R10: Each load that reaches the fetch step makes exactly one memory request. `memReq` stays high and `memAddr` stays steady until `memAck` is sampled.
- R11: A result that is decided without a fetch appears in the second cycle after the cycle whose rising edge accepts `startReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a validation (accepted when idle) |
| targetReg | input | 3 | Target register: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| selector | input | 16 | Selector being loaded |
| gdtBase | input | ADDR_W | Global table base address |
| gdtLimit | input | LIMIT_W | Global table limit (last valid byte offset) |
| ldtBase | input | ADDR_W | Local table base address |
| ldtLimit | input | LIMIT_W | Local table limit |
| ldtValid | input | 1 | A local table is loaded |
| memReq | output | 1 | Descriptor read request |
| memAddr | output | ADDR_W | Descriptor byte address |
| memAck | input | 1 | Read acknowledge with data |
| memData | input | 64 | Descriptor returned with `memAck` |
| busy | output | 1 | A validation is in progress |
| loadDone | output | 1 | One-cycle success strobe |
| loadNull | output | 1 | Register loaded as null (with `loadDone`) |
| loadSel | output | 16 | Selector to cache (with `loadDone`) |
| cacheBase | output | 32 | Descriptor base to cache |
| cacheLimit | output | 20 | Raw descriptor limit to cache |
| cacheAttr | output | 12 | Descriptor flags and access byte |
| faultValid | output | 1 | One-cycle fault strobe |
| faultVector | output | 8 | Exception vector: 11, 12 or 13 |
| faultCode | output | 16 | Error code |

## Verification
The bench goes after the table-limit edge. One case sets the limit exactly to index × 8 + 7 and another sets it one below. A comparison that is off by one, or that tests the start of the entry rather than its end, gets one of the two cases wrong, or issues a read it should not. Null selectors are driven with non-zero low bits at every target. A design that compares the whole selector against zero would fault or fetch where it must not, and one that mixes up the per-register rules would accept a null CS or SS. The bench also sends a not-present descriptor whose type is wrong, and a not-present descriptor to SS. These show whether type is checked before presence, and whether the stack vector is chosen rather than the not-present vector. A random memory acknowledge delay exposes a request that drops early or an address that moves while the request is waiting.

// File: rtl/selv_pkg.sv
package selv_pkg;
  localparam int DESC_W = 64;
  localparam int SEL_W  = 16;

  localparam logic [2:0] TGT_CS = 3'd1;
  localparam logic [2:0] TGT_SS = 3'd2;

  localparam logic [7:0] VEC_GP  = 8'd13;
  localparam logic [7:0] VEC_NP  = 8'd11;
  localparam logic [7:0] VEC_STK = 8'd12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_FETCH, ST_CHECK, ST_DONE, ST_FAULT
  } selv_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capIn;
    logic capDesc;
    logic logDecFault;
    logic logChkFault;
    logic setNull;
  } selv_strb_t;

  // datapath -> control status
  typedef struct packed {
    logic decFault;
    logic decNull;
    logic chkFault;
  } selv_stat_t;
endpackage

// File: rtl/selv_ctrl.sv
module selv_ctrl
  import selv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       memAck,
  input  selv_stat_t stat,
  output selv_strb_t strb,
  output logic       memReq,
  output logic       busy,
  output logic       loadDone,
  output logic       faultValid
);
  selv_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (startReq) nextState = ST_DECODE;
      ST_DECODE: begin
        if (stat.decFault)     nextState = ST_FAULT;
        else if (stat.decNull) nextState = ST_DONE;
        else                   nextState = ST_FETCH;
      end
      ST_FETCH:  if (memAck) nextState = ST_CHECK;
      ST_CHECK:  nextState = stat.chkFault ? ST_FAULT : ST_DONE;
      ST_DONE:   nextState = ST_IDLE;
      ST_FAULT:  nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.capIn       = (state == ST_IDLE) && startReq;
    strb.capDesc     = (state == ST_FETCH) && memAck;
    strb.logDecFault = (state == ST_DECODE) && stat.decFault;
    strb.setNull     = (state == ST_DECODE) && !stat.decFault && stat.decNull;
    strb.logChkFault = (state == ST_CHECK) && stat.chkFault;
  end

  assign memReq     = (state == ST_FETCH);
  assign busy       = (state != ST_IDLE);
  assign loadDone   = (state == ST_DONE);
  assign faultValid = (state == ST_FAULT);

  // R10: an outstanding request is not withdrawn before acknowledge
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);

  // R9: success strobe lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);
endmodule

// File: rtl/selv_dpath.sv
module selv_dpath
  import selv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  selv_strb_t          strb,
  input  logic [2:0]          targetReg,
  input  logic [SEL_W-1:0]    selector,
  input  logic [ADDR_W-1:0]   gdtBase,
  input  logic [LIMIT_W-1:0]  gdtLimit,
  input  logic [ADDR_W-1:0]   ldtBase,
  input  logic [LIMIT_W-1:0]  ldtLimit,
  input  logic                ldtValid,
  input  logic [DESC_W-1:0]   memData,
  output selv_stat_t          stat,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                loadNull,
  output logic [SEL_W-1:0]    loadSel,
  output logic [31:0]         cacheBase,
  output logic [19:0]         cacheLimit,
  output logic [11:0]         cacheAttr,
  output logic [7:0]          faultVector,
  output logic [SEL_W-1:0]    faultCode
);
  localparam int IDX_W = SEL_W - 3;
  localparam int CMP_W = (LIMIT_W > SEL_W ? LIMIT_W : SEL_W) + 1;

  logic [SEL_W-1:0]   selQ;
  logic [2:0]         tgtQ;
  logic [ADDR_W-1:0]  tblBaseQ;
  logic [LIMIT_W-1:0] tblLimQ;
  logic               ldtOkQ;
  logic [DESC_W-1:0]  descQ;
  logic               nullQ;
  logic [7:0]         vecQ;
  logic [SEL_W-1:0]   codeQ;

  // decode stage
  logic [IDX_W-1:0] idx;
  logic             tiLdt, isNullSel, isDataTgt, outRange;
  logic [SEL_W-1:0] selCode, decCode;

  always_comb begin
    idx       = selQ[SEL_W-1:3];
    tiLdt     = selQ[2];
    isNullSel = (selQ[SEL_W-1:2] == '0);
    isDataTgt = (tgtQ != TGT_CS) && (tgtQ != TGT_SS);
    outRange  = CMP_W'({idx, 3'b111}) > CMP_W'(tblLimQ);
    selCode   = {selQ[SEL_W-1:2], 2'b00};
    decCode   = isNullSel ? '0 : selCode;
    stat.decNull  = isNullSel && isDataTgt;
    stat.decFault = isNullSel ? !isDataTgt
                              : ((tiLdt && !ldtOkQ) || outRange);
  end

  assign memAddr = tblBaseQ + ADDR_W'({idx, 3'b000});

  // attribute check stage
  logic       segFlag, present, typeOk;
  logic [3:0] segType;
  logic [7:0] chkVec;

  always_comb begin
    segFlag = descQ[44];
    segType = descQ[43:40];
    present = descQ[47];
    if (tgtQ == TGT_CS)      typeOk = segFlag && segType[3];
    else if (tgtQ == TGT_SS) typeOk = segFlag && !segType[3] && segType[1];
    else                     typeOk = segFlag && (!segType[3] || segType[1]);
    if (!typeOk)             chkVec = VEC_GP;
    else if (tgtQ == TGT_SS) chkVec = VEC_STK;
    else                     chkVec = VEC_NP;
    stat.chkFault = !typeOk || !present;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0; tgtQ <= '0; tblBaseQ <= '0; tblLimQ <= '0; ldtOkQ <= 1'b0;
      descQ <= '0; nullQ <= 1'b0; vecQ <= '0; codeQ <= '0;
    end else begin
      if (strb.capIn) begin
        selQ     <= selector;
        tgtQ     <= targetReg;
        tblBaseQ <= selector[2] ? ldtBase : gdtBase;
        tblLimQ  <= selector[2] ? ldtLimit : gdtLimit;
        ldtOkQ   <= ldtValid;
        descQ    <= '0;
        nullQ    <= 1'b0;
      end
      if (strb.capDesc) descQ <= memData;
      if (strb.setNull) nullQ <= 1'b1;
      if (strb.logDecFault) begin
        vecQ  <= VEC_GP;
        codeQ <= decCode;
      end
      if (strb.logChkFault) begin
        vecQ  <= chkVec;
        codeQ <= selCode;
      end
    end
  end

  assign loadNull    = nullQ;
  assign loadSel     = selQ;
  assign cacheBase   = {descQ[63:56], descQ[39:16]};
  assign cacheLimit  = {descQ[51:48], descQ[15:0]};
  assign cacheAttr   = {descQ[55:52], descQ[47:40]};
  assign faultVector = vecQ;
  assign faultCode   = codeQ;
endmodule

// File: rtl/seg_sel_validator.sv
module seg_sel_validator
  import selv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [2:0]         targetReg,
  input  logic [15:0]        selector,
  input  logic [ADDR_W-1:0]  gdtBase,
  input  logic [LIMIT_W-1:0] gdtLimit,
  input  logic [ADDR_W-1:0]  ldtBase,
  input  logic [LIMIT_W-1:0] ldtLimit,
  input  logic               ldtValid,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memAck,
  input  logic [63:0]        memData,
  output logic               busy,
  output logic               loadDone,
  output logic               loadNull,
  output logic [15:0]        loadSel,
  output logic [31:0]        cacheBase,
  output logic [19:0]        cacheLimit,
  output logic [11:0]        cacheAttr,
  output logic               faultValid,
  output logic [7:0]         faultVector,
  output logic [15:0]        faultCode
);
  selv_strb_t strb;
  selv_stat_t stat;

  selv_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memAck(memAck),
    .stat(stat), .strb(strb), .memReq(memReq), .busy(busy),
    .loadDone(loadDone), .faultValid(faultValid)
  );

  selv_dpath #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .targetReg(targetReg),
    .selector(selector), .gdtBase(gdtBase), .gdtLimit(gdtLimit),
    .ldtBase(ldtBase), .ldtLimit(ldtLimit), .ldtValid(ldtValid),
    .memData(memData), .stat(stat), .memAddr(memAddr),
    .loadNull(loadNull), .loadSel(loadSel), .cacheBase(cacheBase),
    .cacheLimit(cacheLimit), .cacheAttr(cacheAttr),
    .faultVector(faultVector), .faultCode(faultCode)
  );

  // R10: address held while the request waits
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));

  // R8: not-present and stack vectors only arise after a fetched descriptor
  assert_np_after_fetch_R8: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && (faultVector != VEC_GP) |-> $past(memAck, 2));

  // R5: a zero error code only comes with vector 13
  assert_zero_code_gp_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && (faultCode == 16'h0) |-> faultVector == VEC_GP);

  // R6: a null load caches empty descriptor fields
  assert_null_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadDone && loadNull |-> (cacheBase == 32'h0) && (cacheLimit == 20'h0)
                             && (cacheAttr == 12'h0));
endmodule

// File: tb/seg_sel_validator_test.sv
module seg_sel_validator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [2:0]  targetReg = '0;
  logic [15:0] selector = '0;
  logic [31:0] gdtBase = '0, ldtBase = '0;
  logic [15:0] gdtLimit = '0, ldtLimit = '0;
  logic        ldtValid = 1'b0;
  logic        memReq, memAck = 1'b0;
  logic [31:0] memAddr;
  logic [63:0] memData = '0;
  logic        busy, loadDone, loadNull, faultValid;
  logic [15:0] loadSel, faultCode;
  logic [31:0] cacheBase;
  logic [19:0] cacheLimit;
  logic [11:0] cacheAttr;
  logic [7:0]  faultVector;

  int checks = 0, failures = 0, cycles = 0;
  logic [63:0] memDesc = '0;
  int ackDelay = 0, waitCnt = 0, ackCount = 0;
  logic [31:0] lastAddr = '0;

  seg_sel_validator uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .targetReg(targetReg),
    .selector(selector), .gdtBase(gdtBase), .gdtLimit(gdtLimit),
    .ldtBase(ldtBase), .ldtLimit(ldtLimit), .ldtValid(ldtValid),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .busy(busy), .loadDone(loadDone), .loadNull(loadNull), .loadSel(loadSel),
    .cacheBase(cacheBase), .cacheLimit(cacheLimit), .cacheAttr(cacheAttr),
    .faultValid(faultValid), .faultVector(faultVector), .faultCode(faultCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finishRun();
    end
  end

  // memory responder with variable delay
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (waitCnt >= ackDelay) begin
        memAck = 1'b1; memData = memDesc; lastAddr = memAddr;
        ackCount++; waitCnt = 0;
      end else waitCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkDesc(input logic [31:0] base, input logic [19:0] lim,
      input logic [3:0] typ, input bit s, input logic [1:0] dpl, input bit p,
      input logic [3:0] flg);
    return {base[31:24], flg, lim[19:16], p, dpl, s, typ, base[23:0], lim[15:0]};
  endfunction

  // expected behaviour computed from the requirements
  task automatic model(input logic [2:0] tgt, input logic [15:0] sel,
      input logic [63:0] d, output bit eFault, output bit eNull,
      output logic [7:0] eVec, output logic [15:0] eCode, output bit eFetch,
      output logic [31:0] eAddr, output string eReq);
    logic [31:0] base; logic [15:0] lim; int endOff; bit dataTgt; bit tyOk;
    dataTgt = (tgt != 3'd1) && (tgt != 3'd2);
    base = sel[2] ? ldtBase : gdtBase;
    lim  = sel[2] ? ldtLimit : gdtLimit;
    endOff = int'(sel[15:3]) * 8 + 7;
    eAddr = base + 32'(sel[15:3]) * 8;
    eFault = 0; eNull = 0; eVec = 0; eCode = {sel[15:2], 2'b00}; eFetch = 0; eReq = "R9";
    if (sel[15:2] == 0) begin
      if (dataTgt) begin eNull = 1; eReq = "R6"; end
      else begin eFault = 1; eVec = 13; eCode = 0; eReq = "R5"; end
    end else if (sel[2] && !ldtValid) begin
      eFault = 1; eVec = 13; eReq = "R4";
    end else if (endOff > int'(lim)) begin
      eFault = 1; eVec = 13; eReq = "R3";
    end else begin
      eFetch = 1;
      if (tgt == 3'd1)      tyOk = d[44] && d[43];
      else if (tgt == 3'd2) tyOk = d[44] && !d[43] && d[41];
      else                  tyOk = d[44] && (!d[43] || d[41]);
      if (!tyOk) begin eFault = 1; eVec = 13; eReq = "R7"; end
      else if (!d[47]) begin eFault = 1; eVec = (tgt == 3'd2) ? 12 : 11; eReq = "R8"; end
    end
  endtask

  task automatic runCase(input logic [2:0] tgt, input logic [15:0] sel, input logic [63:0] d);
    bit eFault, eNull, eFetch; logic [7:0] eVec; logic [15:0] eCode;
    logic [31:0] eAddr; string eReq; int n; int ack0;
    model(tgt, sel, d, eFault, eNull, eVec, eCode, eFetch, eAddr, eReq);
    @(negedge clk);
    targetReg = tgt; selector = sel; memDesc = d; ackDelay = $urandom_range(0, 3);
    waitCnt = 0; ack0 = ackCount; startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0; n = 1;
    while (!(loadDone || faultValid) && n < 40) begin @(negedge clk); n++; end
    check(eFault ? faultValid : loadDone, eReq, "outcome kind",
          {62'd0, faultValid, loadDone}, {62'd0, eFault, !eFault});
    if (eFault) begin
      check(faultVector == eVec, eReq, "fault vector", 64'(faultVector), 64'(eVec));
      check(faultCode == eCode, eReq, "error code", 64'(faultCode), 64'(eCode));
    end else begin
      check(loadNull == eNull, eReq, "null flag", 64'(loadNull), 64'(eNull));
      check(loadSel == sel, "R9", "loaded selector", 64'(loadSel), 64'(sel));
      check(cacheBase == (eNull ? 32'h0 : {d[63:56], d[39:16]}), eReq, "cache base",
            64'(cacheBase), 64'(eNull ? 32'h0 : {d[63:56], d[39:16]}));
      check(cacheLimit == (eNull ? 20'h0 : {d[51:48], d[15:0]}), eReq, "cache limit",
            64'(cacheLimit), 64'(eNull ? 20'h0 : {d[51:48], d[15:0]}));
      check(cacheAttr == (eNull ? 12'h0 : {d[55:52], d[47:40]}), eReq, "cache attr",
            64'(cacheAttr), 64'(eNull ? 12'h0 : {d[55:52], d[47:40]}));
    end
    check((ackCount - ack0) == (eFetch ? 1 : 0), "R10", "request count",
          64'(ackCount - ack0), 64'(eFetch ? 1 : 0));
    if (eFetch) check(lastAddr == eAddr, "R2", "descriptor address", 64'(lastAddr), 64'(eAddr));
    else check(n == 2, "R11", "decode latency", 64'(n), 64'd2);
    @(negedge clk);
    check(!loadDone && !faultValid, "R9", "strobe width", {62'd0, loadDone, faultValid}, 64'd0);
  endtask

  initial begin
    logic [63:0] goodData, goodCode, roData, xoCode, sysD;
    void'($urandom(32'd4242));
    gdtBase = 32'h0010_0000; gdtLimit = 16'h00FF;
    ldtBase = 32'h0020_0040; ldtLimit = 16'h007F; ldtValid = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !memReq && !loadDone && !faultValid, "R1", "reset outputs",
          {60'd0, busy, memReq, loadDone, faultValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq, "R1", "idle after reset", {62'd0, busy, memReq}, 64'd0);

    goodData = mkDesc(32'h1234_5678, 20'hABCDE, 4'h3, 1, 2'd0, 1, 4'hC);
    goodCode = mkDesc(32'h0, 20'hFFFFF, 4'hB, 1, 2'd0, 1, 4'hC);
    roData   = mkDesc(32'h4000, 20'h0FFF, 4'h1, 1, 2'd3, 1, 4'h4);
    xoCode   = mkDesc(32'h8000, 20'h00FF, 4'h8, 1, 2'd0, 1, 4'h4);
    sysD     = mkDesc(32'h8000, 20'h00FF, 4'h2, 0, 2'd0, 1, 4'h0);

    runCase(3'd1, 16'h0000, goodCode);              // R5 null CS
    runCase(3'd2, 16'h0003, goodData);              // R5 null SS with RPL bits
    runCase(3'd3, 16'h0002, goodData);              // R6 null DS with RPL bits
    runCase(3'd5, 16'h0000, goodData);              // R6 null GS
    ldtValid = 1'b0;
    runCase(3'd3, 16'h0014, goodData);              // R4 local table absent
    ldtValid = 1'b1;
    runCase(3'd3, 16'h0014, goodData);              // R2 local table fetch
    gdtLimit = 16'h004F;
    runCase(3'd3, 16'h0048, goodData);              // R3 entry ends exactly at limit
    gdtLimit = 16'h004E;
    runCase(3'd3, 16'h0048, goodData);              // R3 entry one byte past limit
    gdtLimit = 16'h00FF;
    runCase(3'd2, 16'h0010, roData);                // R7 read-only data into SS
    runCase(3'd1, 16'h0010, goodData);              // R7 data into CS
    runCase(3'd4, 16'h0010, xoCode);                // R7 execute-only into FS
    runCase(3'd0, 16'h0010, sysD);                  // R7 system descriptor
    runCase(3'd2, 16'h0018, goodData & ~(64'd1 << 47)); // R8 not-present SS -> 12
    runCase(3'd3, 16'h0018, goodData & ~(64'd1 << 47)); // R8 not-present DS -> 11
    runCase(3'd1, 16'h0018, goodData & ~(64'd1 << 47)); // R7 before R8: wrong type wins
    runCase(3'd1, 16'h0021, goodCode);              // R9 good CS
    runCase(3'd2, 16'h0012, goodData);              // R9 good SS

    for (int i = 0; i < 300; i++) begin
      logic [63:0] d; logic [15:0] s;
      gdtLimit = 16'(($urandom_range(2, 24) * 8) - 1 - $urandom_range(0, 1));
      ldtLimit = 16'(($urandom_range(1, 16) * 8) - 1);
      gdtBase  = $urandom & 32'hFFFF_FFF0;
      ldtBase  = $urandom;
      ldtValid = ($urandom_range(0, 7) != 0);
      d = {$urandom, $urandom};
      if ($urandom_range(0, 4) != 0) d[47] = 1'b1;
      if ($urandom_range(0, 3) != 0) d[44] = 1'b1;
      s = {13'($urandom_range(0, 26)), 3'($urandom)};
      runCase(3'($urandom_range(0, 7)), s, d);
    end
    finishRun();
  end
endmodule